// File: doc/BRIEF.md
# Half-Flash Converter Bus Sequencer

This block is the digital control core of an 8-bit converter with a microprocessor-style bus. The result is built in two 4-bit steps. A coarse flash step gives the upper nibble. A fine step on the residue gives the lower nibble. Both nibbles reach the block as digital codes. The block decides when each code is captured and when the host may see the result. It drives an active-low end-of-conversion strobe, an output enable for the data bus, and an open-drain ready pull-down. In one bus mode that ready pull-down shares its pin with the write input.

There are two bus modes, chosen by a level input. In write-read mode, a write pulse starts the conversion and an internal cycle count finishes it. A read issued early cuts that count short. Tying chip select and read low gives stand-alone use, where each write pulse starts a new conversion while the previous result is still on the bus. In read mode, a read strobe starts the conversion and the ready output holds the host off until data is valid.

A power-down input aborts any conversion in progress. After wake-up, a programmable number of cycles must pass before a start is accepted. Any start that arrives too early is dropped, and that drop is recorded in a sticky error flag. All bus pins pass through a two-flop synchroniser and an edge detector. Every response therefore lands three clock edges after the pin changes.

Top module: `hfc_seq`

## Requirements
- R1: `mode`=1 selects write-read mode (write pin is a start input, ready pull-down never active); `mode`=0 selects read mode (read strobe starts conversions, write pin unused).
- R2: In write-read mode a falling `wr_n` with `cs_n` low starts a conversion. The rising `wr_n` captures `coarse_code` into bits [7:4]. After another FINE_CYC cycles, `fine_code` is captured into bits [3:0] and `int_n` falls. Each pin change acts on the third clock edge after it.
- R3: `int_n` falls only when a complete result is valid. It returns high on a rising `cs_n` or `rd_n`, and when a new conversion starts.
- R4: In write-read mode, a falling `rd_n` with `cs_n` low during the fine step ends the conversion at once: the fine code is captured and `int_n` falls without waiting for FINE_CYC.
- R5: `data_oe` is high only while `cs_n` and `rd_n` are both low and the result is valid. `data_out` then carries {upper nibble, lower nibble}, with bit 7 as the MSB.
- R6: In read mode a falling `rd_n` with `cs_n` low starts a conversion. `data_oe` stays low until it finishes, RD_CYC cycles later, when `int_n` falls and the full code is presented.
- R7: In read mode, `rdy_pull_low` is high while `cs_n` is low and no valid result exists. A falling `cs_n` marks the old result stale, and `rdy_pull_low` releases when the conversion ends.
- R8: In stand-alone use (`cs_n`=`rd_n`=0, write-read mode), the previous result stays on the bus with `data_oe` high while the next `wr_n` pulse is low. The new result replaces it after the pulse.
- R9: While `pwrdn_n` is low no conversion runs. After `pwrdn_n` rises, starts are ignored for WAKE_CYC cycles, and the previous result and `int_n` are left unchanged.
- R10: A start that is ignored because of power-down or wake-up sets `err_flag`, which stays high until reset. `err_flag` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that times all internal delays |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low (write-read mode) |
| mode | input | 1 | 1 = write-read mode, 0 = read mode |
| pwrdn_n | input | 1 | Power-down request, active low |
| coarse_code | input | NIB_W | Code from the coarse flash step |
| fine_code | input | NIB_W | Code from the residue flash step |
| data_out | output | 2*NIB_W | Result register |
| data_oe | output | 1 | Enable for the bus drivers of `data_out` |
| int_n | output | 1 | End-of-conversion strobe, active low |
| rdy_pull_low | output | 1 | Pulls the shared ready pin low when high |
| err_flag | output | 1 | Sticky flag for ignored start requests |

## Verification
The assertions assume that every bus pin holds each level for at least three clocks, so the synchroniser never loses a pulse. They also assume that `mode` changes only while no conversion is running. The bench drives all pins half a cycle away from the active edge and holds each level for three or more cycles. It changes `mode` only with `cs_n` high and the sequencer idle, then waits for the new level to settle. The nibble codes are held steady from the start of each conversion until its end, which matches the assumption that the flash stages settle before capture.

// File: rtl/hfc_pkg.sv
// Shared types for the half-flash bus sequencer.
package hfc_pkg;

    // Conversion sequencer states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,  // waiting for a start request
        ST_SAMPLE = 2'd1,  // write strobe low, coarse step tracking
        ST_FINE   = 2'd2,  // upper nibble held, residue step running
        ST_RCONV  = 2'd3   // read-initiated conversion running
    } conv_state_t;

    // Index of each bus pin inside the synchroniser vector
    localparam int PIN_WR  = 0;
    localparam int PIN_RD  = 1;
    localparam int PIN_CS  = 2;
    localparam int PIN_MD  = 3;
    localparam int PIN_PD  = 4;
    localparam int PIN_CNT = 5;

endpackage

// File: rtl/hfc_sync.sv
// Multi-stage synchroniser for asynchronous bus pins.
// Assumes each input level is held longer than STAGES clocks.
// RST_VAL gives the idle level of each bit after reset.
module hfc_sync #(
    parameter int          W       = 5,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop samples the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= din;
                end
            end else begin : g_next
                // Later flops settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/hfc_edge.sv
// Edge detector on synchronised levels.
// Gives one-cycle rise and fall pulses for each bit.
module hfc_edge #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] prev_q;

    // Keep last cycle's level for comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl;
    end

    assign rise = ~prev_q & lvl;
    assign fall = prev_q & ~lvl;

endmodule

// File: rtl/hfc_wake.sv
// Wake-up timer. It is not ready while power-down is requested, nor for
// WAKE_CYC cycles after the request is released. Reset counts as a wake-up.
module hfc_wake #(
    parameter int WAKE_CYC = 45
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    output logic asleep,
    output logic ready
);

    localparam int WCNT_W = $clog2(WAKE_CYC + 1);

    logic [WCNT_W-1:0] wcnt_q;
    logic              done_q;

    assign asleep = pd_req;

    // Count the wake interval down while power-down is released
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= WCNT_W'(WAKE_CYC - 1);
            done_q <= 1'b0;
        end else if (pd_req) begin
            wcnt_q <= WCNT_W'(WAKE_CYC - 1);
            done_q <= 1'b0;
        end else if (wcnt_q != '0) begin
            wcnt_q <= wcnt_q - 1'b1;
        end else begin
            done_q <= 1'b1;
        end
    end

    assign ready = done_q & ~pd_req;

endmodule

// File: rtl/hfc_conv.sv
// Conversion sequencer. It captures the coarse and fine nibbles, times the
// fine step and read-mode conversions, and drives the result-valid flag,
// the end-of-conversion strobe and the sticky error flag.
// Assumes edge pulses come from synchronised pins and mode is stable
// during a conversion.
module hfc_conv
    import hfc_pkg::*;
#(
    parameter int NIB_W    = 4,
    parameter int FINE_CYC = 8,
    parameter int RD_CYC   = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_wr,
    input  logic               cs_lo,
    input  logic               wr_fall,
    input  logic               wr_rise,
    input  logic               rd_fall,
    input  logic               rd_rise,
    input  logic               cs_fall,
    input  logic               cs_rise,
    input  logic               asleep,
    input  logic               ready,
    input  logic [NIB_W-1:0]   coarse,
    input  logic [NIB_W-1:0]   fine,
    output logic [2*NIB_W-1:0] result,
    output logic               valid,
    output logic               int_n,
    output logic               err,
    output conv_state_t        state
);

    localparam int CMAX  = (FINE_CYC > RD_CYC) ? FINE_CYC : RD_CYC;
    localparam int CNT_W = $clog2(CMAX + 1);

    conv_state_t        state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [NIB_W-1:0]   upper_q;
    logic [NIB_W-1:0]   lower_q;
    logic               valid_q;
    logic               int_q;
    logic               err_q;
    logic               start_wr;
    logic               start_rd;
    logic               early_rd;

    assign start_wr = mode_wr & cs_lo & wr_fall;
    assign start_rd = ~mode_wr & cs_lo & rd_fall;
    assign early_rd = cs_lo & rd_fall;

    // Main sequencer: state, nibble capture, valid and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            upper_q <= '0;
            lower_q <= '0;
            valid_q <= 1'b0;
            int_q   <= 1'b1;
        end else if (asleep) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            if (rd_rise || cs_rise) int_q <= 1'b1;
            if (!mode_wr && cs_fall) valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_wr && ready) begin
                        state_q <= ST_SAMPLE;
                        int_q   <= 1'b1;
                    end else if (start_rd && ready) begin
                        state_q <= ST_RCONV;
                        upper_q <= coarse;
                        valid_q <= 1'b0;
                        int_q   <= 1'b1;
                        cnt_q   <= CNT_W'(RD_CYC - 1);
                    end
                end
                ST_SAMPLE: begin
                    if (wr_rise) begin
                        state_q <= ST_FINE;
                        upper_q <= coarse;
                        valid_q <= 1'b0;
                        cnt_q   <= CNT_W'(FINE_CYC - 1);
                    end
                end
                ST_FINE: begin
                    if (early_rd || cnt_q == '0) begin
                        state_q <= ST_IDLE;
                        lower_q <= fine;
                        valid_q <= 1'b1;
                        int_q   <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_RCONV: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_IDLE;
                        lower_q <= fine;
                        valid_q <= 1'b1;
                        int_q   <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Sticky record of starts dropped while not ready
    always_ff @(posedge clk) begin
        if (!rst_n)                                err_q <= 1'b0;
        else if ((start_wr || start_rd) && !ready) err_q <= 1'b1;
    end

    assign result = {upper_q, lower_q};
    assign valid  = valid_q;
    assign int_n  = int_q;
    assign err    = err_q;
    assign state  = state_q;

endmodule

// File: rtl/hfc_seq.sv
// Top of the half-flash bus sequencer. It synchronises the bus pins,
// detects their edges, runs the wake timer and the conversion sequencer,
// and forms the bus enable and ready pull-down.
// Assumes bus pins are asynchronous to clk and held at least three cycles.
module hfc_seq
    import hfc_pkg::*;
#(
    parameter int NIB_W    = 4,
    parameter int WAKE_CYC = 45,
    parameter int FINE_CYC = 8,
    parameter int RD_CYC   = 14,
    parameter int SYNC_STG = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic               mode,
    input  logic               pwrdn_n,
    input  logic [NIB_W-1:0]   coarse_code,
    input  logic [NIB_W-1:0]   fine_code,
    output logic [2*NIB_W-1:0] data_out,
    output logic               data_oe,
    output logic               int_n,
    output logic               rdy_pull_low,
    output logic               err_flag
);

    localparam logic [PIN_CNT-1:0] PIN_IDLE = 5'b10111;

    logic [PIN_CNT-1:0] pins_raw;
    logic [PIN_CNT-1:0] pins_s;
    logic [2:0]         strobe_lvl;
    logic [2:0]         strobe_rise;
    logic [2:0]         strobe_fall;
    logic               cs_s;
    logic               rd_s;
    logic               mode_s;
    logic               asleep;
    logic               wake_ready;
    logic               res_valid;
    conv_state_t        conv_state;

    assign pins_raw[PIN_WR] = wr_n;
    assign pins_raw[PIN_RD] = rd_n;
    assign pins_raw[PIN_CS] = cs_n;
    assign pins_raw[PIN_MD] = mode;
    assign pins_raw[PIN_PD] = pwrdn_n;

    hfc_sync #(
        .W       (PIN_CNT),
        .STAGES  (SYNC_STG),
        .RST_VAL (PIN_IDLE)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .dout  (pins_s)
    );

    assign cs_s       = pins_s[PIN_CS];
    assign rd_s       = pins_s[PIN_RD];
    assign mode_s     = pins_s[PIN_MD];
    assign strobe_lvl = {pins_s[PIN_CS], pins_s[PIN_RD], pins_s[PIN_WR]};

    hfc_edge #(
        .W       (3),
        .RST_VAL (3'b111)
    ) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (strobe_lvl),
        .rise  (strobe_rise),
        .fall  (strobe_fall)
    );

    hfc_wake #(
        .WAKE_CYC (WAKE_CYC)
    ) wake_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pd_req (~pins_s[PIN_PD]),
        .asleep (asleep),
        .ready  (wake_ready)
    );

    hfc_conv #(
        .NIB_W    (NIB_W),
        .FINE_CYC (FINE_CYC),
        .RD_CYC   (RD_CYC)
    ) conv_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_wr (mode_s),
        .cs_lo   (~cs_s),
        .wr_fall (strobe_fall[0]),
        .wr_rise (strobe_rise[0]),
        .rd_fall (strobe_fall[1]),
        .rd_rise (strobe_rise[1]),
        .cs_fall (strobe_fall[2]),
        .cs_rise (strobe_rise[2]),
        .asleep  (asleep),
        .ready   (wake_ready),
        .coarse  (coarse_code),
        .fine    (fine_code),
        .result  (data_out),
        .valid   (res_valid),
        .int_n   (int_n),
        .err     (err_flag),
        .state   (conv_state)
    );

    // Bus drivers on only for a selected read of a valid result
    assign data_oe      = res_valid & ~cs_s & ~rd_s;
    // Ready held low in read mode while selected and result not valid
    assign rdy_pull_low = ~mode_s & ~cs_s & ~res_valid;

endmodule

// File: rtl/hfc_seq_chk.sv
// Assertion checker for hfc_seq, attached by bind.
// Assumes bus pins are held at least three cycles per level.
module hfc_seq_chk
    import hfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        data_oe,
    input  logic        int_n,
    input  logic        rdy_pull_low,
    input  logic        err_flag,
    input  logic        mode_s,
    input  logic        cs_s,
    input  logic        res_valid,
    input  logic        wake_ready,
    input  logic        rd_fall,
    input  conv_state_t conv_state
);

    // R5: bus enabled only if CS and RD were both low at the pins
    a_r5_oe_selected: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> ($past(cs_n, 2) == 1'b0 && $past(rd_n, 2) == 1'b0));

    // R9: the sequencer leaves idle only when the wake timer is ready
    a_r9_start_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_state != ST_IDLE && $past(conv_state) == ST_IDLE) |-> $past(wake_ready));

    // R10: error flag never clears outside reset
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R3: strobe falls only together with a valid result
    a_r3_int_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> res_valid);

    // R1: ready pull-down never active in write-read mode
    a_r1_rdy_mode: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_pull_low |-> !mode_s);

    // R4: early selected read during fine step ends the conversion
    a_r4_early_read: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_state == ST_FINE && rd_fall && !cs_s) |=> (!int_n && res_valid));

endmodule

bind hfc_seq hfc_seq_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .rd_n         (rd_n),
    .data_oe      (data_oe),
    .int_n        (int_n),
    .rdy_pull_low (rdy_pull_low),
    .err_flag     (err_flag),
    .mode_s       (mode_s),
    .cs_s         (cs_s),
    .res_valid    (res_valid),
    .wake_ready   (wake_ready),
    .rd_fall      (strobe_fall[1]),
    .conv_state   (conv_state)
);

// File: tb/hfc_seq_tb.sv
// Self-checking bench for hfc_seq with small cycle counts.
module hfc_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NIB        = 4;
    localparam int WAKE       = 20;
    localparam int FINE       = 12;
    localparam int RCONV      = 10;
    localparam int WDOG_CYC   = 150000;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           cs_n, rd_n, wr_n, mode, pwrdn_n;
    logic [NIB-1:0] coarse_code, fine_code;
    logic [7:0]     data_out;
    logic           data_oe, int_n, rdy_pull_low, err_flag;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    hfc_seq #(
        .NIB_W    (NIB),
        .WAKE_CYC (WAKE),
        .FINE_CYC (FINE),
        .RD_CYC   (RCONV),
        .SYNC_STG (2)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .rd_n         (rd_n),
        .wr_n         (wr_n),
        .mode         (mode),
        .pwrdn_n      (pwrdn_n),
        .coarse_code  (coarse_code),
        .fine_code    (fine_code),
        .data_out     (data_out),
        .data_oe      (data_oe),
        .int_n        (int_n),
        .rdy_pull_low (rdy_pull_low),
        .err_flag     (err_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG_CYC && !done) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: act %0d cycles exp < %0d", cycles, WDOG_CYC);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks = n_checks + 1;
        if (act != exp) begin
            n_fails = n_fails + 1;
            $display("FAIL %s: act %0h exp %0h", req, act, exp);
        end
    endtask

    // Write-read conversion, normal or early read; cs_n already low
    task automatic wr_conv(input int c, input int f, input bit fast);
        coarse_code = NIB'(c);
        fine_code   = NIB'(f);
        wr_n = 1'b0; tick(3);
        wr_n = 1'b1;
        if (fast) begin
            tick(3);
            chk("R4 int before early read", int_n, 1);
            rd_n = 1'b0; tick(3);
            chk("R4 int after early read", int_n, 0);
        end else begin
            tick(FINE + 2);
            chk("R2 int before fine done", int_n, 1);
            chk("R5 oe with rd high", data_oe, 0);
            tick(1);
            chk("R2 int at fine done", int_n, 0);
            rd_n = 1'b0; tick(3);
        end
        chk("R5 oe on read", data_oe, 1);
        chk("R2 code", data_out, c * 16 + f);
        rd_n = 1'b1; tick(3);
        chk("R3 int after rd rise", int_n, 1);
        chk("R5 oe after rd rise", data_oe, 0);
    endtask

    // Read-mode conversion; cs_n high on entry, high again on exit
    task automatic rd_conv(input int c, input int f);
        coarse_code = NIB'(c);
        fine_code   = NIB'(f);
        cs_n = 1'b0; tick(3);
        chk("R7 rdy after cs fall", rdy_pull_low, 1);
        rd_n = 1'b0; tick(RCONV + 2);
        chk("R6 int during conv", int_n, 1);
        chk("R6 oe during conv", data_oe, 0);
        chk("R7 rdy during conv", rdy_pull_low, 1);
        tick(1);
        chk("R6 int at end", int_n, 0);
        chk("R6 oe at end", data_oe, 1);
        chk("R6 code", data_out, c * 16 + f);
        chk("R7 rdy released", rdy_pull_low, 0);
        cs_n = 1'b1; rd_n = 1'b1; tick(3);
        chk("R3 int after cs rise", int_n, 1);
        chk("R5 oe after deselect", data_oe, 0);
    endtask

    initial begin
        int prev;
        rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        mode = 1'b1; pwrdn_n = 1'b1; coarse_code = '0; fine_code = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R3 reset int", int_n, 1);
        chk("R5 reset oe", data_oe, 0);
        chk("R1 reset rdy", rdy_pull_low, 0);
        chk("R10 reset err", err_flag, 0);
        tick(WAKE + 5);

        // R2 full sweep of both nibbles in write-read mode
        cs_n = 1'b0; tick(3);
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 16; f++)
                wr_conv(c, f, 1'b0);
        chk("R1 no rdy in write-read", rdy_pull_low, 0);

        // R4 early read across codes
        for (int k = 0; k < 16; k++)
            wr_conv(k, 15 - k, 1'b1);

        // R6/R7 read mode
        cs_n = 1'b1; mode = 1'b0; tick(4);
        for (int k = 0; k < 16; k++)
            rd_conv((k * 5) % 16, (k * 11 + 3) % 16);
        chk("R1 write pin ignored in read mode", int_n, 1);
        wr_n = 1'b0; tick(3); wr_n = 1'b1; tick(FINE + 5);
        chk("R1 wr pulse no conversion", int_n, 1);

        // R8 stand-alone
        mode = 1'b1; tick(4);
        cs_n = 1'b0; rd_n = 1'b0;
        coarse_code = 4'h3; fine_code = 4'h9;
        wr_n = 1'b0; tick(3); wr_n = 1'b1; tick(FINE + 3);
        chk("R8 first result", data_out, 8'h39);
        chk("R8 first oe", data_oe, 1);
        prev = 'h39;
        for (int k = 1; k < 9; k++) begin
            coarse_code = NIB'(k * 3);
            fine_code   = NIB'(16 - k);
            wr_n = 1'b0; tick(3);
            chk("R8 old data during wr low", data_out, prev);
            chk("R8 oe during wr low", data_oe, 1);
            chk("R3 int high at new start", int_n, 1);
            wr_n = 1'b1; tick(FINE + 3);
            prev = ((k * 3) % 16) * 16 + (16 - k);
            chk("R8 new data", data_out, prev);
        end
        rd_n = 1'b1; tick(3);
        chk("R3 int after stand-alone", int_n, 1);

        // R9/R10 power-down and wake interval
        chk("R10 err clear before", err_flag, 0);
        pwrdn_n = 1'b0; tick(5);
        pwrdn_n = 1'b1; tick(1);
        coarse_code = 4'hA; fine_code = 4'h5;
        wr_n = 1'b0; tick(3); wr_n = 1'b1; tick(FINE + 5);
        chk("R9 start ignored on wake", int_n, 1);
        chk("R10 err set", err_flag, 1);
        rd_n = 1'b0; tick(3);
        chk("R9 old result kept", data_out, prev);
        chk("R9 old result valid", data_oe, 1);
        rd_n = 1'b1; tick(WAKE + 5);
        wr_conv(4'hA, 4'h5, 1'b0);
        chk("R10 err stays set", err_flag, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule